// File: doc/BRIEF.md
# AT-Bus 16-Bit Cycle Width Resolver

This block decides, for every cycle on a PC/AT-style expansion bus, whether the transfer runs 16 bits wide or 8 bits wide. The two active-low 16-bit select lines are shared, open-drain lines. Each line is read at its own moment. The memory select is captured when ALE falls. The I/O select is captured on the first bus-clock rise after an I/O command strobe goes low. A memory cycle looks only at the memory select, and an I/O cycle looks only at the I/O select, so a card that pulls the other line has no effect.

The block also answers for on-board resources by pulling the select lines low through open-drain enables. It claims the memory select for a ROM read when the ROM is configured 16 bits wide. It also claims it for any access to local DRAM. The ROM and DRAM address decoders sit outside the block and arrive as hit inputs. The block claims the I/O select for a relocatable pair of expanded-memory ports. The pair sits at 0x208/0x209 or at 0x218/0x219. For the odd port of the pair, the block tells the data path to use the upper byte lane. A word access that starts on the odd port is not claimed, so it is reported as 8-bit and gets split.

Top module: `atbus_width_res`

## Requirements
- R1: After reset, wide16_o, width_vld_o, mem16_oe_o, io16_oe_o and hi_lane_o are all 0.
- R2: In a memory cycle (cyc_mem_i=1), the width comes from mem16_n_i at the first clock rise on which ale_i is seen low after being high. 16-bit is reported when the line is 0. Later changes of the line in that cycle do not alter wide16_o.
- R3: In an I/O cycle, the width comes from io16_n_i on the first clock rise with iord_n_i or iowr_n_i low. 16-bit is reported when the line is 0. Later changes of the line before the next ALE do not alter wide16_o.
- R4: A memory cycle ignores io16_n_i, and an I/O cycle ignores mem16_n_i. With no select low at the sampling point, wide16_o is 0.
- R5: mem16_oe_o is asserted for a memory read (cyc_wr_i=0) with rom_hit_i=1 only when rom16_cfg_i=1. It is never asserted for a ROM write.
- R6: mem16_oe_o is asserted for any memory read or write with dram_hit_i=1.
- R7: The port pair is decoded on address bits 15:0 only. The even port is at 0x208 when ems_alt_i=0 and at 0x218 when ems_alt_i=1; the odd port is one above it. Other I/O addresses are never claimed.
- R8: A byte access (word_i=0) to either port, or a word access (word_i=1) at the even port, asserts io16_oe_o.
- R9: hi_lane_o is 1 during an I/O cycle whose address is the odd port, whether the access is a byte or a word.
- R10: A word access starting at the odd port does not assert io16_oe_o. With no external select, it is reported as 8-bit.
- R11: width_vld_o rises at the sampling point and stays 1, with wide16_o unchanged, until the clock rise that first sees ale_i high for the next cycle. At that rise both clear.
- R12: The claim enables are driven only from ALE through the command. They drop in the same cycle that the command strobe is seen released. The two enables are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch enable, high at cycle start |
| addr_i | input | ADDR_W | Latched byte address, bit 0 included |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| cyc_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_wr_i | input | 1 | 1 = write cycle |
| memrd_n_i | input | 1 | Memory read strobe, active low |
| memwr_n_i | input | 1 | Memory write strobe, active low |
| iord_n_i | input | 1 | I/O read strobe, active low |
| iowr_n_i | input | 1 | I/O write strobe, active low |
| rom_hit_i | input | 1 | External decoder: address is in on-board ROM |
| dram_hit_i | input | 1 | External decoder: address is in local DRAM |
| rom16_cfg_i | input | 1 | On-board ROM is 16 bits wide |
| ems_alt_i | input | 1 | Selects the upper location of the port pair |
| mem16_n_i | input | 1 | Observed memory 16-bit select line, active low |
| io16_n_i | input | 1 | Observed I/O 16-bit select line, active low |
| wide16_o | output | 1 | 1 = 16-bit cycle |
| width_vld_o | output | 1 | wide16_o is valid |
| mem16_oe_o | output | 1 | Pull the memory select line low |
| io16_oe_o | output | 1 | Pull the I/O select line low |
| hi_lane_o | output | 1 | Odd-port data moves on D8-D15 |

## Verification
The bench builds the block with the default parameters. The 24-bit address lets an I/O address with bits above 15 set show that only the low 16 bits are decoded. The 16-bit port base and step put both locations of the port pair within reach. The bench models both select lines as wired-AND of an external card and the block's own enable. This lets it exercise self-claimed cycles, cycles claimed by a card, cycles claimed by the wrong line, and late changes on a line after it has been sampled.

// File: rtl/awr_pkg.sv
package awr_pkg;

  // Even-port address of the expanded-memory pair for a given location bit.
  function automatic logic [15:0] pair_even(input logic alt,
                                            input logic [15:0] base,
                                            input logic [15:0] step);
    return alt ? (base + step) : base;
  endfunction

  // True when the low 16 address bits hit either port of the pair.
  function automatic logic pair_hit(input logic [15:0] a16, input logic alt,
                                    input logic [15:0] base,
                                    input logic [15:0] step);
    logic [15:0] ev;
    ev = pair_even(alt, base, step);
    return a16[15:1] == ev[15:1];
  endfunction

  // Port pair answers 16-bit unless a word starts on the odd port.
  function automatic logic pair_claims(input logic hit, input logic word,
                                       input logic a0);
    return hit && (!word || !a0);
  endfunction

  // On-board memory answers 16-bit: wide ROM read or any DRAM access.
  function automatic logic mem_claims(input logic rom_hit, input logic rom16,
                                      input logic wr, input logic dram_hit);
    return (rom_hit && rom16 && !wr) || dram_hit;
  endfunction

endpackage

// File: rtl/awr_cycle_track.sv
module awr_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ale,
  input  logic cmd_act,
  output logic ale_rise,
  output logic ale_fall,
  output logic cmd_end,
  output logic cyc_win
);
  logic ale_q, cmd_q, open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      cmd_q  <= 1'b0;
      open_q <= 1'b0;
    end else begin
      ale_q <= ale;
      cmd_q <= cmd_act;
      if (ale && !ale_q)          open_q <= 1'b1;
      else if (cmd_q && !cmd_act) open_q <= 1'b0;
    end
  end

  assign ale_rise = ale && !ale_q;
  assign ale_fall = !ale && ale_q;
  assign cmd_end  = cmd_q && !cmd_act;
  assign cyc_win  = ale || (open_q && !cmd_end);
endmodule

// File: rtl/awr_claim.sv
module awr_claim #(
  parameter int          ADDR_W   = 24,
  parameter logic [15:0] PAIR_BASE = 16'h0208,
  parameter logic [15:0] ALT_STEP  = 16'h0010
) (
  input  logic              cyc_win,
  input  logic              cyc_mem,
  input  logic              cyc_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  input  logic              rom_hit,
  input  logic              dram_hit,
  input  logic              rom16,
  input  logic              alt,
  output logic              mem_oe,
  output logic              io_oe,
  output logic              hi_lane
);
  import awr_pkg::*;
  localparam int IO_W = 16;

  logic [IO_W-1:0] a16;
  logic            hit;

  assign a16     = addr[IO_W-1:0];
  assign hit     = pair_hit(a16, alt, PAIR_BASE, ALT_STEP);
  assign mem_oe  = cyc_win && cyc_mem && mem_claims(rom_hit, rom16, cyc_wr, dram_hit);
  assign io_oe   = cyc_win && !cyc_mem && pair_claims(hit, word, a16[0]);
  assign hi_lane = cyc_win && !cyc_mem && hit && a16[0];
endmodule

// File: rtl/awr_sampler.sv
module awr_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ale_rise,
  input  logic ale_fall,
  input  logic cyc_win,
  input  logic cyc_mem,
  input  logic io_cmd,
  input  logic mem_line_n,
  input  logic io_line_n,
  output logic mem_smp,
  output logic io_smp,
  output logic wide_q,
  output logic vld_q
);
  logic io_taken_q;

  assign mem_smp = ale_fall && cyc_mem;
  assign io_smp  = io_cmd && !cyc_mem && cyc_win && !ale_rise && !io_taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q     <= 1'b0;
      vld_q      <= 1'b0;
      io_taken_q <= 1'b0;
    end else if (ale_rise) begin
      wide_q     <= 1'b0;
      vld_q      <= 1'b0;
      io_taken_q <= 1'b0;
    end else if (mem_smp) begin
      wide_q <= !mem_line_n;
      vld_q  <= 1'b1;
    end else if (io_smp) begin
      wide_q     <= !io_line_n;
      vld_q      <= 1'b1;
      io_taken_q <= 1'b1;
    end
  end
endmodule

// File: rtl/atbus_width_res.sv
module atbus_width_res #(
  parameter int          ADDR_W    = 24,
  parameter logic [15:0] PAIR_BASE = 16'h0208,
  parameter logic [15:0] ALT_STEP  = 16'h0010
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic              cyc_mem_i,
  input  logic              cyc_wr_i,
  input  logic              memrd_n_i,
  input  logic              memwr_n_i,
  input  logic              iord_n_i,
  input  logic              iowr_n_i,
  input  logic              rom_hit_i,
  input  logic              dram_hit_i,
  input  logic              rom16_cfg_i,
  input  logic              ems_alt_i,
  input  logic              mem16_n_i,
  input  logic              io16_n_i,
  output logic              wide16_o,
  output logic              width_vld_o,
  output logic              mem16_oe_o,
  output logic              io16_oe_o,
  output logic              hi_lane_o
);
  // Named internal events, also observed by the bound checker.
  logic io_cmd, cmd_act;
  logic ale_rise, ale_fall, cmd_end, cyc_win;
  logic mem_smp, io_smp;

  assign io_cmd  = !iord_n_i || !iowr_n_i;
  assign cmd_act = io_cmd || !memrd_n_i || !memwr_n_i;

  awr_cycle_track u_trk (
    .clk(bus_clk), .rst_n(rst_n), .ale(ale_i), .cmd_act(cmd_act),
    .ale_rise(ale_rise), .ale_fall(ale_fall), .cmd_end(cmd_end),
    .cyc_win(cyc_win)
  );

  awr_claim #(.ADDR_W(ADDR_W), .PAIR_BASE(PAIR_BASE), .ALT_STEP(ALT_STEP)) u_clm (
    .cyc_win(cyc_win), .cyc_mem(cyc_mem_i), .cyc_wr(cyc_wr_i),
    .addr(addr_i), .word(word_i), .rom_hit(rom_hit_i),
    .dram_hit(dram_hit_i), .rom16(rom16_cfg_i), .alt(ems_alt_i),
    .mem_oe(mem16_oe_o), .io_oe(io16_oe_o), .hi_lane(hi_lane_o)
  );

  awr_sampler u_smp (
    .clk(bus_clk), .rst_n(rst_n), .ale_rise(ale_rise), .ale_fall(ale_fall),
    .cyc_win(cyc_win), .cyc_mem(cyc_mem_i), .io_cmd(io_cmd),
    .mem_line_n(mem16_n_i), .io_line_n(io16_n_i),
    .mem_smp(mem_smp), .io_smp(io_smp),
    .wide_q(wide16_o), .vld_q(width_vld_o)
  );
endmodule

// File: rtl/atbus_width_res_chk.sv
module atbus_width_res_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic ale_rise,
  input logic cmd_end,
  input logic mem_smp,
  input logic io_smp,
  input logic mem_line_n,
  input logic io_line_n,
  input logic wide,
  input logic vld,
  input logic mem_oe,
  input logic io_oe
);
  p_mem_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_smp |=> (vld && wide == !$past(mem_line_n)));

  p_io_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_smp |=> (vld && wide == !$past(io_line_n)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !ale) |=> ($stable(wide) && vld));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ale_rise |=> !vld);

  p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |-> (!mem_oe && !io_oe));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_oe, io_oe}));
endmodule

bind atbus_width_res atbus_width_res_chk chk_i (
  .clk(bus_clk), .rst_n(rst_n), .ale(ale_i), .ale_rise(ale_rise),
  .cmd_end(cmd_end), .mem_smp(mem_smp), .io_smp(io_smp),
  .mem_line_n(mem16_n_i), .io_line_n(io16_n_i), .wide(wide16_o),
  .vld(width_vld_o), .mem_oe(mem16_oe_o), .io_oe(io16_oe_o)
);

// File: tb/atbus_width_res_tb_top.sv
module atbus_width_res_tb_top;
  localparam int ADDR_W = 24;

  typedef struct packed {
    logic        mem, wr;
    logic [23:0] addr;
    logic        word, rom, dram, rom16, alt, xm, xi;
    logic        ew, emo, eio, ehi;
    logic [3:0]  req;
  } vec_t;

  // Row fields: mem wr addr word rom dram rom16 alt xm xi | ew emo eio ehi req
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1,0,24'h0F0000,1,1,0,1,0,1,1, 1,1,0,0, 5},  // R5 wide ROM read
    '{1,0,24'h0F0000,1,1,0,0,0,1,1, 0,0,0,0, 5},  // R5 narrow ROM
    '{1,1,24'h0F0000,1,1,0,1,0,1,1, 0,0,0,0, 5},  // R5 ROM write
    '{1,1,24'h012340,1,0,1,0,0,1,1, 1,1,0,0, 6},  // R6 DRAM write
    '{1,0,24'h012340,0,0,1,0,0,1,1, 1,1,0,0, 6},  // R6 DRAM read
    '{1,0,24'h0C8000,1,0,0,0,0,0,1, 1,0,0,0, 2},  // R2 card memory select
    '{1,0,24'h0C8000,1,0,0,0,0,1,0, 0,0,0,0, 4},  // R4 I/O line in mem cycle
    '{0,0,24'h000208,0,0,0,0,0,1,1, 1,0,1,0, 8},  // R8 even byte
    '{0,1,24'h000209,0,0,0,0,0,1,1, 1,0,1,1, 9},  // R9 odd byte high lane
    '{0,0,24'h000208,1,0,0,0,0,1,1, 1,0,1,0, 8},  // R8 even word
    '{0,1,24'h000209,1,0,0,0,0,1,1, 0,0,0,1,10},  // R10 odd word split
    '{0,0,24'h000218,0,0,0,0,0,1,1, 0,0,0,0, 7},  // R7 wrong location
    '{0,0,24'h000219,0,0,0,0,1,1,1, 1,0,1,1, 7},  // R7 alternate location
    '{0,0,24'h000300,1,0,0,0,0,1,0, 1,0,0,0, 3},  // R3 card I/O select
    '{0,0,24'h000300,1,0,0,0,0,0,1, 0,0,0,0, 4},  // R4 mem line in I/O cycle
    '{0,0,24'h010208,0,0,1,0,0,1,1, 1,0,1,0, 7}   // R7 upper bits ignored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ale = 0, word = 0, cmem = 0, cwr = 0;
  logic memrd_n = 1, memwr_n = 1, iord_n = 1, iowr_n = 1;
  logic rom = 0, dram = 0, rom16 = 0, alt = 0, xm = 1, xi = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic wide, vld, moe, ioe, hi;
  logic mline, iline;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Open-drain lines: external card AND the block's own pull-down.
  assign mline = xm & ~moe;
  assign iline = xi & ~ioe;

  atbus_width_res #(.ADDR_W(ADDR_W)) dut_i (
    .bus_clk(clk), .rst_n(rst_n), .ale_i(ale), .addr_i(addr), .word_i(word),
    .cyc_mem_i(cmem), .cyc_wr_i(cwr), .memrd_n_i(memrd_n), .memwr_n_i(memwr_n),
    .iord_n_i(iord_n), .iowr_n_i(iowr_n), .rom_hit_i(rom), .dram_hit_i(dram),
    .rom16_cfg_i(rom16), .ems_alt_i(alt), .mem16_n_i(mline), .io16_n_i(iline),
    .wide16_o(wide), .width_vld_o(vld), .mem16_oe_o(moe), .io16_oe_o(ioe),
    .hi_lane_o(hi)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmd_on(input logic m, input logic w);
    if (m) begin memrd_n = w; memwr_n = !w; end
    else   begin iord_n = w;  iowr_n = !w; end
  endtask

  task automatic cmd_off();
    memrd_n = 1; memwr_n = 1; iord_n = 1; iowr_n = 1;
  endtask

  // Opens a cycle: ALE high for one clock, then low with the command on.
  task automatic open_cycle(input vec_t v);
    @(negedge clk);
    cmem = v.mem; cwr = v.wr; addr = v.addr; word = v.word; rom = v.rom;
    dram = v.dram; rom16 = v.rom16; alt = v.alt; xm = v.xm; xi = v.xi;
    ale = 1;
    @(negedge clk);
    chk("R11 cleared at ALE", vld, 1'b0);
    ale = 0;
    cmd_on(v.mem, v.wr);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wide", wide, 0); chk("R1 vld", vld, 0);
    chk("R1 moe", moe, 0);   chk("R1 ioe", ioe, 0); chk("R1 hi", hi, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      open_cycle(TBL[i]);
      $display("vector %0d checks R%0d", i, TBL[i].req);
      chk("vector vld", vld, 1'b1);
      chk("vector wide", wide, TBL[i].ew);
      chk("vector mem oe", moe, TBL[i].emo);
      chk("vector io oe", ioe, TBL[i].eio);
      chk("vector hi lane", hi, TBL[i].ehi);
      @(negedge clk);
      cmd_off();
      #1;
      chk("R12 mem oe released", moe, 1'b0);
      chk("R12 io oe released", ioe, 1'b0);
      @(negedge clk);
      chk("R11 vld held", vld, 1'b1);
      chk("R11 wide held", wide, TBL[i].ew);
    end

    // R2: memory line changes after ALE fall do not matter.
    open_cycle('{1,0,24'h0C8000,1,0,0,0,0,0,1, 1,0,0,0, 2});
    xm = 1;
    repeat (2) @(negedge clk);
    chk("R2 late mem line ignored", wide, 1'b1);
    cmd_off(); @(negedge clk);

    // R3: I/O line released after first sample keeps 16-bit.
    open_cycle('{0,0,24'h000300,1,0,0,0,0,1,0, 1,0,0,0, 3});
    xi = 1;
    repeat (2) @(negedge clk);
    chk("R3 late io line ignored", wide, 1'b1);
    // R3: line asserted late in a narrow cycle does not widen it.
    cmd_off(); @(negedge clk);
    open_cycle('{0,0,24'h000300,1,0,0,0,0,1,1, 0,0,0,0, 3});
    xi = 0;
    repeat (2) @(negedge clk);
    chk("R3 late assertion ignored", wide, 1'b0);
    cmd_off(); xi = 1;

    // R12: no claim outside a cycle even with hits present.
    repeat (2) @(negedge clk);
    cmem = 1; dram = 1;
    #1 chk("R12 no claim idle", moe, 1'b0);
    dram = 0;

    // R11: next ALE clears a valid width.
    @(negedge clk); ale = 1;
    @(negedge clk);
    chk("R11 cleared by next ALE", vld, 1'b0);
    chk("R11 wide cleared", wide, 1'b0);
    ale = 0;

    // R1: reset mid-cycle returns everything to idle.
    open_cycle('{1,0,24'h012340,1,0,1,0,0,1,1, 1,1,0,0, 6});
    rst_n = 0; cmd_off(); dram = 0;
    @(negedge clk);
    chk("R1 vld after reset", vld, 0);
    chk("R1 moe after reset", moe, 0);
    rst_n = 1;
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule